// File: doc/BRIEF.md
# USB Transceiver Power-Up Sequencer

This block controls how a USB transceiver comes out of power-down before the rest of the USB controller may use it. It drives four PHY control bits: an oscillator power-down bit, a PHY power-down bit, a VBUS detect comparator enable and a VBUS sense comparator enable. A power-down bit at 1 means powered down. A comparator enable at 1 means the comparator is on. When a start request arrives, the sequencer releases both power-down bits. One cycle later it switches on both level comparators. It then waits for the PHY clock-good status before it raises `ready`.

The clock-good input counts as valid only after it has been high on two consecutive clock samples. This filters single-cycle glitches. A programmable cycle count guards the wait. If clock-good does not qualify within that count, the machine stops in an error state with `timeout_err` high. The transceiver stays powered so that software can inspect it.

The states are IDLE, RELEASE_PD, ENABLE_CMP, WAIT_CLKGD, READY and ERROR. The named transitions are:
- IDLE→RELEASE_PD on start.
- RELEASE_PD→ENABLE_CMP unconditionally.
- ENABLE_CMP→WAIT_CLKGD unconditionally.
- WAIT_CLKGD→READY on qualified clock-good.
- WAIT_CLKGD→ERROR on timeout.
- READY→WAIT_CLKGD when clock-good drops.
- Any state→IDLE when start is low.

Each transition takes one clock.

Top module: `phy_pwrup_seq`

## Requirements
- R1: A synchronous reset (`rst` high) places the machine in IDLE. In IDLE, `osc_pd`=1, `phy_pd`=1, `vbus_det_en`=0, `vbus_sense_en`=0, `ready`=0 and `timeout_err`=0.
- R2: With `start_req`=1 in IDLE, the next cycle is RELEASE_PD: both power-down bits are 0 and both comparator enables are still 0.
- R3: The cycle after RELEASE_PD is ENABLE_CMP, in which both comparator enables are 1 and both power-down bits stay 0. A comparator enable never rises unless the PHY power-down bit was already 0 in the previous cycle.
- R4: The cycle after ENABLE_CMP is WAIT_CLKGD, with the same control outputs as ENABLE_CMP. The machine stays there until clock-good qualifies or the wait times out.
- R5: Clock-good qualifies only when `clk_good` has been sampled high on two consecutive rising edges. A high level lasting a single cycle is ignored.
- R6: In WAIT_CLKGD, a qualified clock-good moves the machine to READY on the next edge. In READY, `ready`=1 and the comparators stay on. `ready` rises only after `clk_good` was high in the two previous cycles.
- R7: In READY, `clk_good` sampled low moves the machine back to WAIT_CLKGD on the next edge (`ready`=0). The wait window then restarts from zero.
- R8: With `timeout_limit`=L (0 treated as 1), the machine spends at most L cycles in WAIT_CLKGD. It then enters ERROR if clock-good has not qualified. A qualification in the last cycle wins over the timeout. In ERROR, `timeout_err`=1, both power-down bits are 0 and both comparators are on.
- R9: `start_req`=0 returns the machine from any state to IDLE on the next edge.
- R10: ERROR is held for as long as `start_req` stays 1 and reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Power-up request, level, active high |
| clk_good | input | 1 | PHY clock-good status, active high |
| timeout_limit | input | CNT_W (13) | Maximum cycles spent in WAIT_CLKGD |
| osc_pd | output | 1 | Oscillator power-down, 1 = powered down |
| phy_pd | output | 1 | PHY power-down, 1 = powered down |
| vbus_det_en | output | 1 | VBUS detect comparator enable |
| vbus_sense_en | output | 1 | VBUS sense comparator enable |
| ready | output | 1 | Transceiver ready, level |
| timeout_err | output | 1 | Clock-good wait timed out |

## Verification
The assertions check these properties on every cycle:
- Comparators turn on only after the power-down release.
- `ready` rises only after two high samples of clock-good.
- `ready` falls after clock-good drops.
- A dropped start always restores the powered-down IDLE image.
- An error persists while start is held.
- An expired wait without qualification leads to ERROR.

Only the bench scenarios can show the exact arrival cycle of READY or ERROR across the sweep of clock-good delays and limits, including a tie on the last wait cycle and a zero limit. The same applies to the rejection of alternating glitch patterns, the restart of the wait window after a drop, and the default 4096-cycle window.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RELEASE_PD = 3'd1,
        ST_ENABLE_CMP = 3'd2,
        ST_WAIT_CLKGD = 3'd3,
        ST_READY      = 3'd4,
        ST_ERROR      = 3'd5
    } seq_state_t;

    // Control image: {osc_pd, phy_pd, vbus_det_en, vbus_sense_en}
    localparam logic [3:0] CTL_POWERED_DOWN = 4'b1100;
    localparam logic [3:0] CTL_RELEASED     = 4'b0000;
    localparam logic [3:0] CTL_COMPARING    = 4'b0011;

endpackage

// File: rtl/phy_good_qualifier.sv
module phy_good_qualifier #(
    parameter int STABLE_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_good,
    output logic good_q
);
    localparam int HW = STABLE_LEN - 1;

    logic [HW-1:0] hist;

    generate
        if (HW == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= raw_good;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= {hist[HW-2:0], raw_good};
            end
        end
    endgenerate

    // Qualified only when the current sample and all held samples are high.
    assign good_q = raw_good & (&hist);

endmodule

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_next_ext;

    assign cnt_next_ext = {1'b0, cnt} + (CNT_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != {CNT_W{1'b1}})
            cnt <= cnt + CNT_W'(1);
    end

    // Last permitted cycle of the window; a limit of zero behaves as one.
    assign expired = run && (cnt_next_ext >= {1'b0, limit});

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
    import usbphy_seq_pkg::*;
#(
    parameter int CNT_W      = 13,
    parameter int STABLE_LEN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             clk_good,
    input  logic [CNT_W-1:0] timeout_limit,
    output logic             osc_pd,
    output logic             phy_pd,
    output logic             vbus_det_en,
    output logic             vbus_sense_en,
    output logic             ready,
    output logic             timeout_err
);
    seq_state_t state, state_nx;
    logic       good_q;
    logic       wait_expired;
    logic [3:0] ctl_img;

    phy_good_qualifier #(.STABLE_LEN(STABLE_LEN)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .raw_good (clk_good),
        .good_q   (good_q)
    );

    phy_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WAIT_CLKGD),
        .limit   (timeout_limit),
        .expired (wait_expired)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!start_req) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       state_nx = ST_RELEASE_PD;
                ST_RELEASE_PD: state_nx = ST_ENABLE_CMP;
                ST_ENABLE_CMP: state_nx = ST_WAIT_CLKGD;
                ST_WAIT_CLKGD: begin
                    if (good_q)            state_nx = ST_READY;
                    else if (wait_expired) state_nx = ST_ERROR;
                end
                ST_READY:      if (!good_q) state_nx = ST_WAIT_CLKGD;
                ST_ERROR:      state_nx = ST_ERROR;
                default:       state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Output decode
    always_comb begin
        ctl_img     = CTL_POWERED_DOWN;
        ready       = 1'b0;
        timeout_err = 1'b0;
        unique case (state)
            ST_IDLE:       ctl_img = CTL_POWERED_DOWN;
            ST_RELEASE_PD: ctl_img = CTL_RELEASED;
            ST_ENABLE_CMP: ctl_img = CTL_COMPARING;
            ST_WAIT_CLKGD: ctl_img = CTL_COMPARING;
            ST_READY: begin
                ctl_img = CTL_COMPARING;
                ready   = 1'b1;
            end
            ST_ERROR: begin
                ctl_img     = CTL_COMPARING;
                timeout_err = 1'b1;
            end
            default:       ctl_img = CTL_POWERED_DOWN;
        endcase
    end

    assign {osc_pd, phy_pd, vbus_det_en, vbus_sense_en} = ctl_img;

    // Assertions
    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_req) |=>
            (!osc_pd && !phy_pd && !vbus_det_en && !vbus_sense_en));

    p_order_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(vbus_det_en) || $rose(vbus_sense_en)) |-> $past(!phy_pd));

    p_ready_needs_good_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(clk_good, 1) && $past(clk_good, 2)));

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (ready && !clk_good) |=> !ready);

    p_timeout_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_CLKGD && wait_expired && !good_q && start_req) |=>
            (timeout_err && !osc_pd && !phy_pd));

    p_stop_r9: assert property (@(posedge clk) disable iff (rst)
        !start_req |=> (osc_pd && phy_pd && !vbus_det_en && !ready && !timeout_err));

    p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (timeout_err && start_req) |=> timeout_err);

endmodule

// File: tb/sim_phy_pwrup_seq.sv
`timescale 1ns/1ps
module sim_phy_pwrup_seq;

    localparam int CNT_W = 13;
    localparam logic [5:0] V_IDLE  = 6'b110000;
    localparam logic [5:0] V_REL   = 6'b000000;
    localparam logic [5:0] V_CMP   = 6'b001100;
    localparam logic [5:0] V_READY = 6'b001110;
    localparam logic [5:0] V_ERR   = 6'b001101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic clk_good = 1'b0;
    logic [CNT_W-1:0] timeout_limit = '0;
    logic osc_pd, phy_pd, vbus_det_en, vbus_sense_en, ready, timeout_err;
    logic [5:0] outv;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    phy_pwrup_seq #(.CNT_W(CNT_W), .STABLE_LEN(2)) u0 (
        .clk(clk), .rst(rst), .start_req(start_req), .clk_good(clk_good),
        .timeout_limit(timeout_limit), .osc_pd(osc_pd), .phy_pd(phy_pd),
        .vbus_det_en(vbus_det_en), .vbus_sense_en(vbus_sense_en),
        .ready(ready), .timeout_err(timeout_err)
    );

    assign outv = {osc_pd, phy_pd, vbus_det_en, vbus_sense_en, ready, timeout_err};

    task automatic chk(input string tag, input logic [5:0] exp);
        checks++;
        if (outv !== exp) begin
            fails++;
            $display("FAIL %s: outputs=%b expected=%b at %0t", tag, outv, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; start_req = 1'b0; clk_good = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset image", V_IDLE);
    endtask

    // Clock-good rises after edge g (g=0: together with start), limit l.
    task automatic run_case(input int g, input int l);
        int leff, rdy_edge, err_edge;
        logic rdy_path;
        logic [5:0] exp;
        string tag;
        leff     = (l == 0) ? 1 : l;
        rdy_edge = (g + 2 > 4) ? g + 2 : 4;
        err_edge = 3 + leff;
        rdy_path = (rdy_edge <= err_edge);
        do_reset();
        timeout_limit = CNT_W'(l);
        start_req = 1'b1;
        clk_good  = (g == 0);
        for (int c = 1; c <= l + g + 8; c++) begin
            step();
            if (c == 1)      begin exp = V_REL; tag = "R2 release"; end
            else if (c == 2) begin exp = V_CMP; tag = "R3 enable cmp"; end
            else if (rdy_path && c >= rdy_edge) begin exp = V_READY; tag = "R6 ready"; end
            else if (!rdy_path && c >= err_edge) begin exp = V_ERR; tag = "R8 timeout"; end
            else begin exp = V_CMP; tag = "R4 wait"; end
            chk(tag, exp);
            if (c == g) clk_good = 1'b1;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Sweep of clock-good delay against wait limit (R2 R3 R4 R6 R8)
        for (int g = 0; g <= 10; g++)
            for (int l = 0; l <= 8; l++)
                run_case(g, l);

        // R5: alternating single-cycle highs never qualify; timeout at edge 23
        do_reset();
        timeout_limit = CNT_W'(20);
        start_req = 1'b1;
        for (int c = 1; c <= 26; c++) begin
            step();
            if (c >= 23) chk("R5 glitch then R8 error", V_ERR);
            else if (c >= 3) chk("R5 glitch ignored", V_CMP);
            clk_good = (c % 2 == 1);
        end

        // R10: error held while start stays high, then R9 stop
        clk_good = 1'b0;
        for (int c = 0; c < 10; c++) begin
            step();
            chk("R10 error hold", V_ERR);
        end
        start_req = 1'b0;
        step();
        chk("R9 stop from ERROR", V_IDLE);

        // R7: drop from READY back to WAIT, window restarts
        do_reset();
        timeout_limit = CNT_W'(50);
        start_req = 1'b1;
        clk_good  = 1'b1;
        for (int c = 1; c <= 6; c++) step();
        chk("R6 ready held", V_READY);
        clk_good = 1'b0;
        step();
        chk("R7 drop to wait", V_CMP);
        clk_good = 1'b1;
        step();
        chk("R7 requalify pending", V_CMP);
        step();
        chk("R7 ready again", V_READY);

        // R1: reset from READY
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset from READY", V_IDLE);

        // R9: stop from WAIT and from READY
        start_req = 1'b1;
        clk_good  = 1'b0;
        for (int c = 0; c < 4; c++) step();
        chk("R4 waiting", V_CMP);
        start_req = 1'b0;
        step();
        chk("R9 stop from WAIT", V_IDLE);
        start_req = 1'b1;
        clk_good  = 1'b1;
        for (int c = 0; c < 5; c++) step();
        chk("R6 ready", V_READY);
        start_req = 1'b0;
        step();
        chk("R9 stop from READY", V_IDLE);

        // R8: default 4096-cycle window, error after edge 4099
        do_reset();
        timeout_limit = CNT_W'(4096);
        start_req = 1'b1;
        for (int c = 1; c <= 4098; c++) step();
        chk("R8 last wait cycle", V_CMP);
        step();
        chk("R8 default timeout", V_ERR);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule